// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a bank of hardware event counters. There are `N_GP` general-purpose counters, and each one has its own event-select register. There are also `N_FX` fixed-function counters, which share one packed control register. Each counter receives two increment pulses every cycle, one for user-mode events and one for kernel-mode events. It adds each pulse that its controls allow, so a counter can advance by 0, 1 or 2 in a cycle. Which event a counter watches is decided outside the block; only the pulses arrive here.

A counter is visible outside the block only when it has a local enable and its bit in the global-control register is set. When a counter wraps past its width, its bit in the overflow-status vector is set. If that counter's interrupt is enabled, a one-cycle interrupt request is raised. The request is raised only once until the counter is reprogrammed.

Software reaches the block through a 64-bit register port, and an access it may not make is flagged with an error. A second, combinational port reads counter values by index.

Register map (`reg_addr`):

| Address | Register |
|---|---|
| 0x00 + k | general-purpose counter k |
| 0x10 + k | event-select register k |
| 0x20 + i | fixed counter i |
| 0x30 | fixed control |
| 0x31 | global control |
| 0x32 | overflow status (read-only) |
| 0x33 | overflow clear |

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter, event select, fixed control, global control, overflow-clear and overflow-status register reads zero, and `irq` is low.
- R2: Fixed counter i is controlled by the 4-bit field at fixed-control bits [4i+3:4i]. In that field, bit 0 admits kernel pulses, bit 1 admits user pulses and bit 3 enables its interrupt.
- R3: A fixed-control write that sets bit 4i+2 of any field, or any bit at 4*N_FX or above, returns `reg_err`=1 and leaves the register unchanged.
- R4: A counter counts only if its local enable and its global-control bit are both set. General-purpose counter k uses global bit k, and fixed counter i uses global bit 32+i. In an event select, bit 22 enables counting, bit 16 admits user pulses, bit 17 admits kernel pulses and bit 20 enables the interrupt.
- R5: A global-control write that sets a bit with no counter behind it returns `reg_err`=1 and is discarded.
- R6: Writing overflow status always returns `reg_err`=1. A counter that wraps past 2^CNT_W sets its status bit (bit k or bit 32+i).
- R7: An accepted overflow-clear write clears every status bit that is set in the data, and the written value reads back. The write is rejected if it sets a bit outside the implemented counters, but bits 62 and 63 are always allowed.
- R8: A counter write loads data[31:0] sign-extended from bit 31. A counter read returns the value masked to CNT_W bits.
- R9: An event-select write with any of bits 63:32 or bit 21 set returns `reg_err`=1 and is discarded.
- R10: On the fast-read port, `fr_idx[30]`=1 selects the fixed bank and `fr_idx[31]`=1 zeroes bits 63:32 of the result. An index in `fr_idx[29:0]` at or beyond the selected bank's count gives `fr_err`=1 and `fr_data`=0.
- R11: On an overflow with its interrupt enabled, `irq` is high for one cycle. A later overflow of the same counter raises no request until it is reprogrammed. Reprogramming is an accepted write to its event select, a change of its fixed-control field, or a toggle of its global bit.
- R12: A write takes effect at the next clock edge. Increment pulses in the same cycle are added on top of a value written to a counter. An access to an address with no register returns `reg_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr_en | input | 1 | register write request |
| reg_rd_en | input | 1 | register read request |
| reg_addr | input | 8 | register address |
| reg_wdata | input | 64 | write data |
| reg_rdata | output | 64 | read data for `reg_addr` (combinational) |
| reg_err | output | 1 | the current access is illegal |
| gp_evt_usr | input | N_GP | user-mode increment pulses, general-purpose counters |
| gp_evt_krn | input | N_GP | kernel-mode increment pulses, general-purpose counters |
| fx_evt_usr | input | N_FX | user-mode increment pulses, fixed counters |
| fx_evt_krn | input | N_FX | kernel-mode increment pulses, fixed counters |
| fr_idx | input | 32 | fast-read index |
| fr_data | output | 64 | fast-read value |
| fr_err | output | 1 | fast-read index out of range |
| ovf_status | output | 64 | overflow-status vector |
| irq | output | 1 | one-cycle interrupt request |

## Verification
The bound checker watches four behaviours on every cycle. Every illegal write must be flagged with an error: reserved global bits, reserved event-select bits, and any write to the status register. A rejected fixed-control write must leave the fixed-counter enables unchanged. Out-of-range fast-read indices must return zero with an error. Any interrupt request must come with a status bit that is set.

Some behaviours depend on history and exact counts, and only the bench scenarios show them. These are the arithmetic of enabled counting and wrap-around, and the rule that an overflow raises the request only once until reprogramming. They also include sign-extension on counter writes, 32-bit truncation on the fast-read port, and the sum when a counter write meets pulses in the same cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned FX_BASE = 32;
  localparam int unsigned FLD_W   = 4;

  // event-select bit positions
  localparam int unsigned ES_USR  = 16;
  localparam int unsigned ES_KRN  = 17;
  localparam int unsigned ES_INT  = 20;
  localparam int unsigned ES_RSVD = 21;
  localparam int unsigned ES_EN   = 22;

  // register groups (reg_addr[7:4]) and control slots (reg_addr[3:0])
  localparam logic [3:0] GRP_GP_CNT = 4'h0;
  localparam logic [3:0] GRP_GP_SEL = 4'h1;
  localparam logic [3:0] GRP_FX_CNT = 4'h2;
  localparam logic [3:0] GRP_CTRL   = 4'h3;
  localparam logic [3:0] SLOT_FXC   = 4'h0;
  localparam logic [3:0] SLOT_GCTL  = 4'h1;
  localparam logic [3:0] SLOT_STAT  = 4'h2;
  localparam logic [3:0] SLOT_CLR   = 4'h3;

  // bits of global control / status that have a counter behind them
  function automatic logic [REG_W-1:0] impl_mask(input int ngp, input int nfx);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < ngp; k++) m[k] = 1'b1;
    for (int i = 0; i < nfx; i++) m[FX_BASE+i] = 1'b1;
    return m;
  endfunction

  // writable bits of the fixed-control register
  function automatic logic [REG_W-1:0] fxc_ok_mask(input int nfx);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < nfx; i++) begin
      m[FLD_W*i+0] = 1'b1;
      m[FLD_W*i+1] = 1'b1;
      m[FLD_W*i+3] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             cnt_usr,
  input  logic             cnt_krn,
  input  logic             int_en,
  input  logic             rearm,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             fire
);
  logic [CNT_W-1:0] base;
  logic [1:0]       inc;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             fired_q, fired_d, fired_live, fired_ce;

  always_comb begin
    base       = wr_en ? wr_val : cnt_q;
    inc        = {1'b0, cnt_usr} + {1'b0, cnt_krn};
    sum        = {1'b0, base} + {{(CNT_W-1){1'b0}}, inc};
    cnt_d      = sum[CNT_W-1:0];
    wrap       = sum[CNT_W];
    cnt_ce     = wr_en | cnt_usr | cnt_krn;
    fired_live = fired_q & ~rearm;
    fire       = wrap & int_en & ~fired_live;
    fired_d    = fired_live | fire;
    fired_ce   = rearm | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (cnt_ce)   cnt_q   <= cnt_d;
      if (fired_ce) fired_q <= fired_d;
    end
  end
endmodule

// File: rtl/pmc_cfg.sv
module pmc_cfg
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP  = 4,
  parameter int unsigned N_FX  = 3,
  parameter int unsigned CNT_W = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  input  logic [N_GP-1:0][CNT_W-1:0]  gp_cnt,
  input  logic [N_FX-1:0][CNT_W-1:0]  fx_cnt,
  input  logic [REG_W-1:0]            status,
  output logic [REG_W-1:0]            rdata,
  output logic                        err,
  output logic [N_GP-1:0]             gp_wr,
  output logic [N_FX-1:0]             fx_wr,
  output logic [CNT_W-1:0]            cnt_wval,
  output logic                        clr_en,
  output logic [REG_W-1:0]            clr_val,
  output logic [N_GP-1:0]             gp_en_usr,
  output logic [N_GP-1:0]             gp_en_krn,
  output logic [N_GP-1:0]             gp_int,
  output logic [N_GP-1:0]             gp_rearm,
  output logic [N_FX-1:0]             fx_en_usr,
  output logic [N_FX-1:0]             fx_en_krn,
  output logic [N_FX-1:0]             fx_int,
  output logic [N_FX-1:0]             fx_rearm
);
  localparam int unsigned FXC_W = FLD_W * N_FX;
  localparam logic [REG_W-1:0] GMASK  = impl_mask(N_GP, N_FX);
  localparam logic [REG_W-1:0] FXC_OK = fxc_ok_mask(N_FX);
  localparam logic [REG_W-1:0] CLR_OK = GMASK | {2'b11, {(REG_W-2){1'b0}}};

  logic [N_GP-1:0][31:0] sel_q, sel_d;
  logic [FXC_W-1:0]      fxc_q, fxc_d;
  logic [REG_W-1:0]      gctl_q, gctl_d;
  logic [REG_W-1:0]      clr_q, clr_d;

  logic [3:0]      grp, idx;
  logic            rd_bad, wr_bad, acc;
  logic [N_GP-1:0] gp_hit, sel_hit;
  logic [N_FX-1:0] fx_hit;
  logic            fxc_hit, gctl_hit, clr_hit;
  logic            sel_ce, fxc_ce, gctl_ce, clr_ce;

  assign grp = addr[7:4];
  assign idx = addr[3:0];

  // address decode, legality and read mux
  always_comb begin
    rdata    = '0;
    rd_bad   = 1'b1;
    wr_bad   = 1'b1;
    gp_hit   = '0;
    sel_hit  = '0;
    fx_hit   = '0;
    fxc_hit  = 1'b0;
    gctl_hit = 1'b0;
    clr_hit  = 1'b0;
    case (grp)
      GRP_GP_CNT: begin
        for (int k = 0; k < N_GP; k++) begin
          if (idx == 4'(k)) begin
            rdata     = REG_W'(gp_cnt[k]);
            rd_bad    = 1'b0;
            wr_bad    = 1'b0;
            gp_hit[k] = 1'b1;
          end
        end
      end
      GRP_GP_SEL: begin
        for (int k = 0; k < N_GP; k++) begin
          if (idx == 4'(k)) begin
            rdata      = REG_W'(sel_q[k]);
            rd_bad     = 1'b0;
            wr_bad     = (|wdata[63:32]) | wdata[ES_RSVD];
            sel_hit[k] = 1'b1;
          end
        end
      end
      GRP_FX_CNT: begin
        for (int i = 0; i < N_FX; i++) begin
          if (idx == 4'(i)) begin
            rdata     = REG_W'(fx_cnt[i]);
            rd_bad    = 1'b0;
            wr_bad    = 1'b0;
            fx_hit[i] = 1'b1;
          end
        end
      end
      GRP_CTRL: begin
        case (idx)
          SLOT_FXC: begin
            rdata   = REG_W'(fxc_q);
            rd_bad  = 1'b0;
            wr_bad  = |(wdata & ~FXC_OK);
            fxc_hit = 1'b1;
          end
          SLOT_GCTL: begin
            rdata    = gctl_q;
            rd_bad   = 1'b0;
            wr_bad   = |(wdata & ~GMASK);
            gctl_hit = 1'b1;
          end
          SLOT_STAT: begin
            rdata  = status;
            rd_bad = 1'b0;
          end
          SLOT_CLR: begin
            rdata   = clr_q;
            rd_bad  = 1'b0;
            wr_bad  = |(wdata & ~CLR_OK);
            clr_hit = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign acc      = wr_en & ~wr_bad;
  assign err      = wr_en ? wr_bad : (rd_en & rd_bad);
  assign gp_wr    = gp_hit & {N_GP{acc}};
  assign fx_wr    = fx_hit & {N_FX{acc}};
  assign cnt_wval = CNT_W'({{32{wdata[31]}}, wdata[31:0]});
  assign clr_en   = acc & clr_hit;
  assign clr_val  = wdata;

  // next state and reprogram strobes
  always_comb begin
    sel_d  = sel_q;
    fxc_d  = fxc_q;
    gctl_d = gctl_q;
    clr_d  = clr_q;
    sel_ce  = acc & (|sel_hit);
    fxc_ce  = acc & fxc_hit;
    gctl_ce = acc & gctl_hit;
    clr_ce  = acc & clr_hit;
    for (int k = 0; k < N_GP; k++) begin
      if (sel_hit[k]) sel_d[k] = wdata[31:0];
      gp_rearm[k] = (acc & sel_hit[k]) | (gctl_ce & (gctl_q[k] ^ wdata[k]));
    end
    fxc_d  = wdata[FXC_W-1:0];
    gctl_d = wdata;
    clr_d  = wdata;
    for (int i = 0; i < N_FX; i++) begin
      fx_rearm[i] = (fxc_ce & (fxc_q[FLD_W*i +: FLD_W] != wdata[FLD_W*i +: FLD_W]))
                  | (gctl_ce & (gctl_q[FX_BASE+i] ^ wdata[FX_BASE+i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      fxc_q  <= '0;
      gctl_q <= '0;
      clr_q  <= '0;
    end else begin
      if (sel_ce)  sel_q  <= sel_d;
      if (fxc_ce)  fxc_q  <= fxc_d;
      if (gctl_ce) gctl_q <= gctl_d;
      if (clr_ce)  clr_q  <= clr_d;
    end
  end

  // local and global enables combined
  always_comb begin
    for (int k = 0; k < N_GP; k++) begin
      gp_en_usr[k] = sel_q[k][ES_EN] & sel_q[k][ES_USR] & gctl_q[k];
      gp_en_krn[k] = sel_q[k][ES_EN] & sel_q[k][ES_KRN] & gctl_q[k];
      gp_int[k]    = sel_q[k][ES_INT];
    end
    for (int i = 0; i < N_FX; i++) begin
      fx_en_krn[i] = fxc_q[FLD_W*i+0] & gctl_q[FX_BASE+i];
      fx_en_usr[i] = fxc_q[FLD_W*i+1] & gctl_q[FX_BASE+i];
      fx_int[i]    = fxc_q[FLD_W*i+3];
    end
  end
endmodule

// File: rtl/pmc_ovf.sv
module pmc_ovf
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP = 4,
  parameter int unsigned N_FX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_GP-1:0]  gp_wrap,
  input  logic [N_FX-1:0]  fx_wrap,
  input  logic [N_GP-1:0]  gp_fire,
  input  logic [N_FX-1:0]  fx_fire,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_val,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  logic [REG_W-1:0] status_q, status_d, set_vec, clr_mask;
  logic             irq_q, irq_d;

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_GP; k++) set_vec[k] = gp_wrap[k];
    for (int i = 0; i < N_FX; i++) set_vec[FX_BASE+i] = fx_wrap[i];
    clr_mask = clr_en ? clr_val : '0;
    // a new wrap in the clearing cycle wins over the clear
    status_d = (status_q & ~clr_mask) | set_vec;
    irq_d    = (|gp_fire) | (|fx_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;
endmodule

// File: rtl/pmc_fastrd.sv
module pmc_fastrd
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP  = 4,
  parameter int unsigned N_FX  = 3,
  parameter int unsigned CNT_W = 48
) (
  input  logic [31:0]                idx,
  input  logic [N_GP-1:0][CNT_W-1:0] gp_cnt,
  input  logic [N_FX-1:0][CNT_W-1:0] fx_cnt,
  output logic [REG_W-1:0]           data,
  output logic                       err
);
  logic [REG_W-1:0] val;

  always_comb begin
    val = '0;
    err = 1'b1;
    if (idx[30]) begin
      for (int i = 0; i < N_FX; i++) begin
        if (idx[29:0] == 30'(i)) begin
          val = REG_W'(fx_cnt[i]);
          err = 1'b0;
        end
      end
    end else begin
      for (int k = 0; k < N_GP; k++) begin
        if (idx[29:0] == 30'(k)) begin
          val = REG_W'(gp_cnt[k]);
          err = 1'b0;
        end
      end
    end
    if (err)          data = '0;
    else if (idx[31]) data = {32'b0, val[31:0]};
    else              data = val;
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP  = 4,
  parameter int unsigned N_FX  = 3,
  parameter int unsigned CNT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [7:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_err,
  input  logic [N_GP-1:0]   gp_evt_usr,
  input  logic [N_GP-1:0]   gp_evt_krn,
  input  logic [N_FX-1:0]   fx_evt_usr,
  input  logic [N_FX-1:0]   fx_evt_krn,
  input  logic [31:0]       fr_idx,
  output logic [63:0]       fr_data,
  output logic              fr_err,
  output logic [63:0]       ovf_status,
  output logic              irq
);
  logic [N_GP-1:0][CNT_W-1:0] gp_cnt;
  logic [N_FX-1:0][CNT_W-1:0] fx_cnt;
  logic [N_GP-1:0] gp_wr, gp_en_usr, gp_en_krn, gp_int, gp_rearm, gp_wrap, gp_fire;
  logic [N_FX-1:0] fx_wr, fx_en_usr, fx_en_krn, fx_int, fx_rearm, fx_wrap, fx_fire;
  logic [CNT_W-1:0] cnt_wval;
  logic             clr_en;
  logic [REG_W-1:0] clr_val;

  pmc_cfg #(.N_GP(N_GP), .N_FX(N_FX), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .gp_cnt(gp_cnt), .fx_cnt(fx_cnt),
    .status(ovf_status), .rdata(reg_rdata), .err(reg_err),
    .gp_wr(gp_wr), .fx_wr(fx_wr), .cnt_wval(cnt_wval),
    .clr_en(clr_en), .clr_val(clr_val),
    .gp_en_usr(gp_en_usr), .gp_en_krn(gp_en_krn), .gp_int(gp_int), .gp_rearm(gp_rearm),
    .fx_en_usr(fx_en_usr), .fx_en_krn(fx_en_krn), .fx_int(fx_int), .fx_rearm(fx_rearm)
  );

  for (genvar k = 0; k < N_GP; k++) begin : g_gp
    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(gp_wr[k]), .wr_val(cnt_wval),
      .cnt_usr(gp_evt_usr[k] & gp_en_usr[k]), .cnt_krn(gp_evt_krn[k] & gp_en_krn[k]),
      .int_en(gp_int[k]), .rearm(gp_rearm[k]),
      .cnt_q(gp_cnt[k]), .wrap(gp_wrap[k]), .fire(gp_fire[k])
    );
  end

  for (genvar i = 0; i < N_FX; i++) begin : g_fx
    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(fx_wr[i]), .wr_val(cnt_wval),
      .cnt_usr(fx_evt_usr[i] & fx_en_usr[i]), .cnt_krn(fx_evt_krn[i] & fx_en_krn[i]),
      .int_en(fx_int[i]), .rearm(fx_rearm[i]),
      .cnt_q(fx_cnt[i]), .wrap(fx_wrap[i]), .fire(fx_fire[i])
    );
  end

  pmc_ovf #(.N_GP(N_GP), .N_FX(N_FX)) u_ovf (
    .clk(clk), .rst_n(rst_n), .gp_wrap(gp_wrap), .fx_wrap(fx_wrap),
    .gp_fire(gp_fire), .fx_fire(fx_fire), .clr_en(clr_en), .clr_val(clr_val),
    .status(ovf_status), .irq(irq)
  );

  pmc_fastrd #(.N_GP(N_GP), .N_FX(N_FX), .CNT_W(CNT_W)) u_fastrd (
    .idx(fr_idx), .gp_cnt(gp_cnt), .fx_cnt(fx_cnt), .data(fr_data), .err(fr_err)
  );
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
  import pmc_pkg::*;
#(
  parameter int unsigned N_GP = 4,
  parameter int unsigned N_FX = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [7:0]      reg_addr,
  input logic [63:0]     reg_wdata,
  input logic            reg_err,
  input logic [31:0]     fr_idx,
  input logic [63:0]     fr_data,
  input logic            fr_err,
  input logic [63:0]     ovf_status,
  input logic            irq,
  input logic [N_FX-1:0] fx_en_usr,
  input logic [N_FX-1:0] fx_en_krn,
  input logic [N_FX-1:0] fx_int
);
  localparam logic [63:0] GMASK  = impl_mask(N_GP, N_FX);
  localparam logic [63:0] FXC_OK = fxc_ok_mask(N_FX);

  logic wr_fxc, wr_gctl, wr_stat, wr_sel;
  assign wr_fxc  = reg_wr_en && reg_addr == {GRP_CTRL, SLOT_FXC};
  assign wr_gctl = reg_wr_en && reg_addr == {GRP_CTRL, SLOT_GCTL};
  assign wr_stat = reg_wr_en && reg_addr == {GRP_CTRL, SLOT_STAT};
  assign wr_sel  = reg_wr_en && reg_addr[7:4] == GRP_GP_SEL && reg_addr[3:0] < 4'(N_GP);

  // R3: rejected fixed-control write leaves the fixed enables untouched
  a_r3_fxc_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fxc && |(reg_wdata & ~FXC_OK)) |-> reg_err ##1
      ($stable(fx_en_usr) && $stable(fx_en_krn) && $stable(fx_int)));

  // R5: unimplemented global bits reject the write
  a_r5_gctl_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gctl && |(reg_wdata & ~GMASK)) |-> reg_err);

  // R6: overflow status is read-only
  a_r6_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |-> reg_err);

  // R9: reserved event-select bits reject the write
  a_r9_sel_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && ((|reg_wdata[63:32]) || reg_wdata[21])) |-> reg_err);

  // R10: out-of-range fast-read index
  a_r10_fr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ((!fr_idx[30] && fr_idx[29:0] >= 30'(N_GP)) || (fr_idx[30] && fr_idx[29:0] >= 30'(N_FX)))
      |-> (fr_err && fr_data == 64'd0));

  // R11: a request always comes with a recorded overflow
  a_r11_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_status != 64'd0));
endmodule

bind pmc_bank pmc_bank_chk #(.N_GP(N_GP), .N_FX(N_FX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_err(reg_err), .fr_idx(fr_idx), .fr_data(fr_data),
  .fr_err(fr_err), .ovf_status(ovf_status), .irq(irq),
  .fx_en_usr(fx_en_usr), .fx_en_krn(fx_en_krn), .fx_int(fx_int)
);

// File: tb/test_pmc_bank.sv
`timescale 1ns/1ps
module test_pmc_bank;
  localparam int N_GP = 4;
  localparam int N_FX = 3;

  logic        clk, rst_n, reg_wr_en, reg_rd_en;
  logic [7:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata, fr_data, ovf_status;
  logic        reg_err, fr_err, irq;
  logic [N_GP-1:0] gp_evt_usr, gp_evt_krn;
  logic [N_FX-1:0] fx_evt_usr, fx_evt_krn;
  logic [31:0] fr_idx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  pmc_bank #(.N_GP(N_GP), .N_FX(N_FX), .CNT_W(48)) i_pmc_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .gp_evt_usr(gp_evt_usr), .gp_evt_krn(gp_evt_krn),
    .fx_evt_usr(fx_evt_usr), .fx_evt_krn(fx_evt_krn),
    .fr_idx(fr_idx), .fr_data(fr_data), .fr_err(fr_err),
    .ovf_status(ovf_status), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [7:0] A_CNT0 = 8'h00, A_CNT1 = 8'h01, A_CNT2 = 8'h02;
  localparam logic [7:0] A_SEL0 = 8'h10, A_SEL1 = 8'h11, A_SEL2 = 8'h12;
  localparam logic [7:0] A_FX0 = 8'h20, A_FXC = 8'h30, A_GCTL = 8'h31;
  localparam logic [7:0] A_STAT = 8'h32, A_CLR = 8'h33;

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [63:0] d;
    logic [63:0] x;
    logic        e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, A_GCTL, 64'h0, 64'h0, 1'b0, 8'd1},                   // R1
    '{1'b1, A_FXC,  64'h0, 64'h0, 1'b0, 8'd1},                   // R1
    '{1'b1, A_STAT, 64'h0, 64'h0, 1'b0, 8'd1},                   // R1
    '{1'b0, A_SEL0, 64'h43_0000, 64'h0, 1'b0, 8'd4},             // R4
    '{1'b1, A_SEL0, 64'h0, 64'h43_0000, 1'b0, 8'd4},             // R4
    '{1'b0, A_SEL1, 64'h1_0000_0000, 64'h0, 1'b1, 8'd9},         // R9
    '{1'b0, A_SEL1, 64'h20_0000, 64'h0, 1'b1, 8'd9},             // R9
    '{1'b1, A_SEL1, 64'h0, 64'h0, 1'b0, 8'd9},                   // R9
    '{1'b0, A_FXC,  64'h004, 64'h0, 1'b1, 8'd3},                 // R3
    '{1'b0, A_FXC,  64'h1000, 64'h0, 1'b1, 8'd3},                // R3
    '{1'b1, A_FXC,  64'h0, 64'h0, 1'b0, 8'd3},                   // R3
    '{1'b0, A_FXC,  64'hB1B, 64'h0, 1'b0, 8'd2},                 // R2
    '{1'b1, A_FXC,  64'h0, 64'hB1B, 1'b0, 8'd2},                 // R2
    '{1'b0, A_GCTL, 64'h10, 64'h0, 1'b1, 8'd5},                  // R5
    '{1'b0, A_GCTL, 64'h8_0000_0000, 64'h0, 1'b1, 8'd5},         // R5
    '{1'b0, A_GCTL, 64'h7_0000_000F, 64'h0, 1'b0, 8'd5},         // R5
    '{1'b1, A_GCTL, 64'h0, 64'h7_0000_000F, 1'b0, 8'd5},         // R5
    '{1'b0, A_STAT, 64'h0, 64'h0, 1'b1, 8'd6},                   // R6
    '{1'b0, A_CLR,  64'h100_0000_0000, 64'h0, 1'b1, 8'd7},       // R7
    '{1'b0, A_CLR,  64'hC000_0000_0000_0000, 64'h0, 1'b0, 8'd7}, // R7
    '{1'b1, A_CLR,  64'h0, 64'hC000_0000_0000_0000, 1'b0, 8'd7}, // R7
    '{1'b0, A_CNT0, 64'h8000_0000, 64'h0, 1'b0, 8'd8},           // R8
    '{1'b1, A_CNT0, 64'h0, 64'hFFFF_8000_0000, 1'b0, 8'd8},      // R8
    '{1'b0, A_CNT2, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 1'b0, 8'd8}, // R8
    '{1'b1, A_CNT2, 64'h0, 64'h7FFF_FFFF, 1'b0, 8'd8},           // R8
    '{1'b1, 8'h3F,  64'h0, 64'h0, 1'b1, 8'd12},                  // R12
    '{1'b0, 8'h05,  64'h0, 64'h0, 1'b1, 8'd12},                  // R12
    '{1'b1, 8'h23,  64'h0, 64'h0, 1'b1, 8'd12}                   // R12
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic exp_err, input string tag);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    #1 chk({tag, " write err"}, 64'(reg_err), 64'(exp_err));
    @(posedge clk);
    #0.5 reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1;
    chk({tag, " read err"}, 64'(reg_err), 64'(exp_err));
    chk({tag, " read data"}, reg_rdata, exp);
    reg_rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [N_GP-1:0] gu, input logic [N_GP-1:0] gk,
                       input logic [N_FX-1:0] fu, input logic [N_FX-1:0] fk, input int n);
    @(negedge clk);
    gp_evt_usr = gu; gp_evt_krn = gk; fx_evt_usr = fu; fx_evt_krn = fk;
    repeat (n) @(posedge clk);
    #0.5;
    gp_evt_usr = '0; gp_evt_krn = '0; fx_evt_usr = '0; fx_evt_krn = '0;
  endtask

  task automatic fread(input logic [31:0] ix, input logic [63:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    fr_idx = ix;
    #1;
    chk({tag, " fast err"}, 64'(fr_err), 64'(exp_err));
    chk({tag, " fast data"}, fr_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    gp_evt_usr = '0; gp_evt_krn = '0; fx_evt_usr = '0; fx_evt_krn = '0; fr_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status", ovf_status, 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VECS[v].req, v);
      if (VECS[v].rd) rd(VECS[v].a, VECS[v].x, VECS[v].e, t);
      else            wr(VECS[v].a, VECS[v].d, VECS[v].e, t);
    end

    // R4: counting needs local and global enable
    wr(A_CNT0, 64'h0, 1'b0, "R4");
    pulse(4'b0001, 4'b0001, '0, '0, 5);
    rd(A_CNT0, 64'd10, 1'b0, "R4 both modes");
    pulse(4'b0010, 4'b0010, '0, '0, 3);
    rd(A_CNT1, 64'd0, 1'b0, "R4 local off");
    wr(A_GCTL, 64'h7_0000_000E, 1'b0, "R4");
    pulse(4'b0001, 4'b0001, '0, '0, 3);
    rd(A_CNT0, 64'd10, 1'b0, "R4 global off");
    wr(A_GCTL, 64'h7_0000_000F, 1'b0, "R4");

    // R2: fixed field 1 = kernel only, field 0 = both modes
    pulse('0, '0, 3'b010, 3'b010, 4);
    fread(32'h4000_0001, 64'd4, 1'b0, "R2 kernel only");
    pulse('0, '0, 3'b001, 3'b000, 2);
    fread(32'h4000_0000, 64'd2, 1'b0, "R2 user");

    // R6 / R11: overflow, one-shot request, rearm
    wr(A_SEL2, 64'h51_0000, 1'b0, "R11");
    wr(A_CNT2, 64'hFFFF_FFFF, 1'b0, "R6");
    pulse(4'b0100, '0, '0, '0, 1);
    chk("R11 irq raised", 64'(irq), 64'h1);
    chk("R6 status bit", ovf_status, 64'h4);
    @(posedge clk); #0.5;
    chk("R11 irq one cycle", 64'(irq), 64'h0);
    rd(A_CNT2, 64'h0, 1'b0, "R6 wrapped");
    wr(A_CNT2, 64'hFFFF_FFFF, 1'b0, "R11");
    pulse(4'b0100, '0, '0, '0, 1);
    chk("R11 no second irq", 64'(irq), 64'h0);
    wr(A_SEL2, 64'h51_0000, 1'b0, "R11 rearm");
    wr(A_CNT2, 64'hFFFF_FFFF, 1'b0, "R11");
    pulse(4'b0100, '0, '0, '0, 1);
    chk("R11 irq after rearm", 64'(irq), 64'h1);
    wr(A_CLR, 64'h4, 1'b0, "R7");
    chk("R7 cleared", ovf_status, 64'h0);
    wr(A_FX0, 64'hFFFF_FFFF, 1'b0, "R6");
    pulse('0, '0, 3'b000, 3'b001, 1);
    chk("R6 fixed status", ovf_status, 64'h1_0000_0000);
    chk("R2 fixed irq", 64'(irq), 64'h1);

    // R10: fast read
    wr(A_CNT0, 64'h8000_0000, 1'b0, "R10");
    fread(32'h0000_0000, 64'hFFFF_8000_0000, 1'b0, "R10 full");
    fread(32'h8000_0000, 64'h8000_0000, 1'b0, "R10 trunc");
    fread(32'h0000_0004, 64'h0, 1'b1, "R10 gp range");
    fread(32'h4000_0003, 64'h0, 1'b1, "R10 fx range");
    fread(32'h4000_0002, 64'h0, 1'b0, "R10 fx last");

    // R12: write and pulses in the same cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_CNT0; reg_wdata = 64'd5;
    gp_evt_usr = 4'b0001; gp_evt_krn = 4'b0001;
    @(posedge clk); #0.5;
    reg_wr_en = 1'b0; gp_evt_usr = '0; gp_evt_krn = '0;
    rd(A_CNT0, 64'd7, 1'b0, "R12 write then count");

    // R1: reset in the middle of a run
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 status after reset", ovf_status, 64'h0);
    chk("R1 irq after reset", 64'(irq), 64'h0);
    rd(A_GCTL, 64'h0, 1'b0, "R1 gctl");
    rd(A_SEL0, 64'h0, 1'b0, "R1 sel");
    fread(32'h0, 64'h0, 1'b0, "R1 counter");
    @(negedge clk) rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule